// File: doc/BRIEF.md
# Event Counter Bank with Software Increment and Privilege Gating

This block holds four 32-bit event counters behind a small register bus. Every counter carries an 8-bit event code. It counts its own hardware event pulse, and software can also bump it through a write-only increment register. The increment takes effect only on counters whose event code is zero, so software stepping shares the counters cleanly with hardware sources.

Software reaches a counter's event code and count value indirectly, through a selection register. A user-enable bit sets whether unprivileged code may touch the registers. Each access is answered in the same cycle. A permitted read returns data. A refused access raises an undefined-access flag and changes nothing. The security-state input is accepted and plays no part in any decision: both states behave the same.

Top module: `pmu_swinc_top`

Register addresses:
- 0: selection, read/write, value in bits 4:0.
- 1: increment, write-only. Bit n asks for one step of counter n.
- 2: user-enable, bit 0.
- 3: event code of the selected counter, bits 7:0.
- 4: count of the selected counter.
- Addresses 5 to 7 read as zero and ignore writes.

Access timing:
- An access happens in a cycle where reg_en is 1. reg_wr is 1 for a write and 0 for a read.
- reg_rdata is zero unless a permitted read is taking place.
- Writes land on the next rising clock edge.

## Requirements
- R1: After a synchronous active-low reset, every count, every event code, the selection register and the user-enable bit read as zero.
- R2: A permitted write to address 1 with bit n set (n = 0..3) adds one to counter n at the next edge. Bits 31:4 of that write have no effect.
- R3: A software increment request for counter n is ignored when counter n's event code is nonzero.
- R4: Any permitted read of address 1 returns zero.
- R5: With user-enable at 0, a user-mode (priv=0) read or write of address 0, 1, 3 or 4 raises reg_undef in that cycle, returns zero data and changes no state.
- R6: With user-enable at 1, user-mode accesses behave exactly like privileged accesses.
- R7: A user-mode write to address 2 raises reg_undef and leaves user-enable unchanged. A user-mode read of address 2 is always permitted. Privileged mode writes it freely.
- R8: When the selection value is above 3, reads of addresses 3 and 4 return zero and writes to them have no effect.
- R9: A software increment and a hardware pulse on the same counter in the same cycle advance it by 2.
- R10: A counter at 0xFFFFFFFF wraps to zero (or to 1 on a double step) with no other effect.
- R11: A count write to a counter in a cycle where it also receives an increment loads the written value, and the increment is dropped.
- R12: The security-state input has no effect on any access result or state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| priv | input | 1 | 1 = privileged access, 0 = user access |
| secure | input | 1 | Security state of the access (no effect) |
| hw_evt | input | 4 | Per-counter hardware event pulses |
| reg_rdata | output | 32 | Read data, zero unless a permitted read |
| reg_undef | output | 1 | Access refused |

## Verification
The increment path is exercised with four kinds of write:
- A mask mixing active and reserved bits, which separates correct bit decoding from bleed-through of the upper bits.
- All four bits set while one counter has a nonzero event code, which shows the event-code gate acting per counter.
- Increments coinciding with hardware pulses and with count writes, which separate additive stepping from write priority.
- Steps on counters preset near the top of their range, which expose carry and wrap handling.

Privilege is covered by repeating the same register accesses in three settings: user mode with the enable bit clear, user mode with the bit set, and privileged mode. Each setting is run under both security states. A behavioural model updated every clock is compared against both outputs on every cycle.

// File: rtl/pmu_pkg.sv
// Shared register addresses and sizes for the event counter bank.
package pmu_pkg;
    localparam int DW     = 32;
    localparam int AW     = 3;
    localparam int NCNT   = 4;
    localparam int CW     = 32;
    localparam int EW     = 8;
    localparam int SW     = 5;

    typedef enum logic [AW-1:0] {
        A_SEL   = 3'd0,
        A_SWINC = 3'd1,
        A_UEN   = 3'd2,
        A_EVT   = 3'd3,
        A_CNT   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/pmu_access_ctl.sv
// Access decoder: checks privilege for each register access and produces
// per-register write strobes and a read-permitted flag.
// Assumes at most one access per cycle; combinational only.
module pmu_access_ctl
    import pmu_pkg::*;
#(
    parameter int ADDR_W = AW
) (
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              priv,
    input  logic              uen,
    output logic              undef,
    output logic              rd_ok,
    output logic              wr_sel,
    output logic              wr_swinc,
    output logic              wr_uen,
    output logic              wr_evt,
    output logic              wr_cnt
);
    logic gated_reg;
    logic refused;
    logic wr_ok;

    // Which registers need user-enable when accessed from user mode.
    always_comb begin
        gated_reg = (reg_addr == A_SEL) || (reg_addr == A_SWINC) ||
                    (reg_addr == A_EVT) || (reg_addr == A_CNT);
    end

    // Refusal: gated register without enable, or user write of the enable bit.
    always_comb begin
        refused = !priv && ((gated_reg && !uen) ||
                            (reg_addr == A_UEN && reg_wr));
        undef   = reg_en && refused;
        rd_ok   = reg_en && !reg_wr && !refused;
        wr_ok   = reg_en &&  reg_wr && !refused;
    end

    // Per-register write strobes.
    always_comb begin
        wr_sel   = wr_ok && (reg_addr == A_SEL);
        wr_swinc = wr_ok && (reg_addr == A_SWINC);
        wr_uen   = wr_ok && (reg_addr == A_UEN);
        wr_evt   = wr_ok && (reg_addr == A_EVT);
        wr_cnt   = wr_ok && (reg_addr == A_CNT);
    end
endmodule

// File: rtl/pmu_counter.sv
// One event counter with its event code. Software step requests count only
// while the event code is zero; the hardware pulse always counts. A count
// write takes precedence over both. Wraps silently at all ones.
module pmu_counter #(
    parameter int CNT_W = 32,
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_req,
    input  logic             hw_evt,
    input  logic             wr_cnt,
    input  logic             wr_evt,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [EVT_W-1:0] evt
);
    logic       sw_hit;
    logic [1:0] step;

    // Amount to add this cycle: 0, 1 or 2.
    always_comb begin
        sw_hit = sw_req && (evt == '0);
        step   = {1'b0, sw_hit} + {1'b0, hw_evt};
    end

    // Count register: reset, load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (wr_cnt) cnt <= wdata;
        else             cnt <= cnt + CNT_W'(step);
    end

    // Event code register.
    always_ff @(posedge clk) begin
        if (!rst_n)      evt <= '0;
        else if (wr_evt) evt <= wdata[EVT_W-1:0];
    end

    // R3
    sw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0 && !hw_evt && !wr_cnt && !wr_evt) |=> (cnt == $past(cnt)));

    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && cnt == '1 && hw_evt) |=> (cnt < CNT_W'(2)));

    // R9
    max_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt) |=> ((cnt - $past(cnt)) <= CNT_W'(2)));
endmodule

// File: rtl/pmu_swinc_top.sv
// Event counter bank with indirect selection, a software increment
// register and user-mode gating. Read data and the refusal flag are
// combinational in the access cycle; writes land on the next edge.
module pmu_swinc_top
    import pmu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_en,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          priv,
    input  logic          secure,
    input  logic [NCNT-1:0] hw_evt,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_undef
);
    localparam int IW = (NCNT > 1) ? $clog2(NCNT) : 1;

    logic          uen_q;
    logic [SW-1:0] sel_q;
    logic          rd_ok, wr_sel, wr_swinc, wr_uen, wr_evt, wr_cnt;
    logic          sel_ok;
    logic [IW-1:0] idx;
    logic [CW-1:0] cnt_arr [NCNT];
    logic [EW-1:0] evt_arr [NCNT];
    logic          unused_inputs;

    assign unused_inputs = ^{secure, reg_wdata[DW-1:CW > SW ? CW : SW]};

    pmu_access_ctl u_acc (
        .reg_en   (reg_en),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .priv     (priv),
        .uen      (uen_q),
        .undef    (reg_undef),
        .rd_ok    (rd_ok),
        .wr_sel   (wr_sel),
        .wr_swinc (wr_swinc),
        .wr_uen   (wr_uen),
        .wr_evt   (wr_evt),
        .wr_cnt   (wr_cnt)
    );

    // Selection decode: in-range flag and counter index.
    always_comb begin
        sel_ok = (32'(sel_q) < NCNT);
        idx    = sel_q[IW-1:0];
    end

    // Selection and user-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            uen_q <= 1'b0;
        end else begin
            if (wr_sel) sel_q <= reg_wdata[SW-1:0];
            if (wr_uen) uen_q <= reg_wdata[0];
        end
    end

    // One counter per slot, each with its own indirect write strobes.
    for (genvar n = 0; n < NCNT; n++) begin : g_cnt
        pmu_counter #(.CNT_W(CW), .EVT_W(EW)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_req (wr_swinc && reg_wdata[n]),
            .hw_evt (hw_evt[n]),
            .wr_cnt (wr_cnt && sel_ok && (idx == IW'(n))),
            .wr_evt (wr_evt && sel_ok && (idx == IW'(n))),
            .wdata  (reg_wdata[CW-1:0]),
            .cnt    (cnt_arr[n]),
            .evt    (evt_arr[n])
        );
    end

    // Read multiplexer, zero unless a permitted read.
    always_comb begin
        reg_rdata = '0;
        if (rd_ok) begin
            case (reg_addr)
                A_SEL: reg_rdata = DW'(sel_q);
                A_UEN: reg_rdata = DW'(uen_q);
                A_EVT: if (sel_ok) reg_rdata = DW'(evt_arr[idx]);
                A_CNT: if (sel_ok) reg_rdata = DW'(cnt_arr[idx]);
                default: reg_rdata = '0;
            endcase
        end
    end

    // R5
    undef_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_undef |-> (reg_rdata == '0));

    // R5
    undef_nostate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_undef |=> ($stable(sel_q) && $stable(uen_q)));

    // R4
    swinc_rz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_wr && reg_addr == A_SWINC) |-> (reg_rdata == '0));

    // R8
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_wr && !sel_ok &&
         (reg_addr == A_CNT || reg_addr == A_EVT)) |-> (reg_rdata == '0));

    // R7
    uen_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_wr && !priv && reg_addr == A_UEN) |=> $stable(uen_q));
endmodule

// File: tb/sim_pmu_swinc_top.sv
module sim_pmu_swinc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_wr = 1'b0, priv = 1'b1, secure = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  hw_evt = '0;
    logic [31:0] reg_rdata;
    logic        reg_undef;

    int total = 0, bad = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural model state
    int unsigned m_cnt [4];
    int unsigned m_evt [4];
    int unsigned m_sel;
    bit          m_uen;

    always #5 clk = ~clk;

    pmu_swinc_top u0 (.*);

    function automatic bit exp_undef();
        if (!reg_en || priv || m_uen) return (reg_en && !priv && reg_addr == 2 && reg_wr);
        return (reg_addr == 0 || reg_addr == 1 || reg_addr == 3 || reg_addr == 4) ||
               (reg_addr == 2 && reg_wr);
    endfunction

    function automatic int unsigned exp_rdata();
        if (!reg_en || reg_wr || exp_undef()) return 0;
        case (reg_addr)
            3'd0: return m_sel;
            3'd2: return {31'd0, m_uen};
            3'd3: return (m_sel < 4) ? m_evt[m_sel] : 0;
            3'd4: return (m_sel < 4) ? m_cnt[m_sel] : 0;
            default: return 0;
        endcase
    endfunction

    task automatic check(string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare outputs, then advance model at posedge.
    task automatic step(bit en, bit wr, int a, int unsigned d, bit pv, bit [3:0] hw);
        bit          u;
        int unsigned r;
        bit          sec_val;
        @(negedge clk);
        sec_val = secure;
        reg_en = en; reg_wr = wr; reg_addr = a[2:0]; reg_wdata = d; priv = pv; hw_evt = hw;
        secure = sec_val;
        #1;
        u = exp_undef();
        r = exp_rdata();
        check("undef", reg_undef, u);
        check("rdata", reg_rdata, r);
        @(posedge clk);
        for (int n = 0; n < 4; n++) begin
            bit ld;
            int unsigned inc;
            ld  = en && wr && !u && a == 4 && m_sel == n;
            inc = ((en && wr && !u && a == 1 && d[n] && m_evt[n] == 0) ? 1 : 0) + (hw[n] ? 1 : 0);
            if (ld) m_cnt[n] = d;
            else    m_cnt[n] = m_cnt[n] + inc;
        end
        if (en && wr && !u) begin
            case (a)
                0: m_sel = d & 32'h1F;
                2: m_uen = d[0];
                3: if (m_sel < 4) m_evt[m_sel] = d & 32'hFF;
                default: ;
            endcase
        end
    endtask

    task automatic rd(int a, bit pv);   step(1, 0, a, 0, pv, 4'h0); endtask
    task automatic wr(int a, int unsigned d, bit pv); step(1, 1, a, d, pv, 4'h0); endtask

    task automatic read_all_counts();
        for (int n = 0; n < 4; n++) begin
            wr(0, n, 1);
            rd(4, 1);
            rd(3, 1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        for (int n = 0; n < 4; n++) begin m_cnt[n] = 0; m_evt[n] = 0; end
        m_sel = 0; m_uen = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        tag = "R1";
        rd(0, 1); rd(2, 1);
        read_all_counts();

        tag = "R2";
        wr(1, 32'hFFFF_FFF5, 1);
        read_all_counts();

        tag = "R3";
        wr(0, 1, 1); wr(3, 32'h11, 1);
        wr(1, 32'hF, 1);
        read_all_counts();

        tag = "R4";
        rd(1, 1);

        tag = "R5";
        wr(0, 3, 1);
        wr(0, 0, 0); wr(1, 32'hF, 0); wr(3, 5, 0); wr(4, 32'h1234, 0);
        rd(0, 0); rd(1, 0); rd(3, 0); rd(4, 0);
        secure = 1'b1;
        wr(1, 32'hF, 0); rd(4, 0);
        secure = 1'b0;
        read_all_counts();

        tag = "R7";
        wr(2, 1, 0); rd(2, 0);
        wr(2, 1, 1); rd(2, 0);
        wr(2, 0, 0); rd(2, 0);

        tag = "R6";
        wr(1, 32'hD, 0); wr(0, 2, 0); rd(0, 0); rd(4, 0); rd(1, 0);
        wr(3, 0, 0); rd(3, 0);
        read_all_counts();

        tag = "R8";
        wr(0, 7, 1); rd(3, 1); rd(4, 1); wr(4, 32'hABCD, 1); wr(3, 9, 1);
        rd(0, 1); rd(4, 0);
        read_all_counts();

        tag = "R9";
        wr(0, 0, 1); rd(4, 1);
        step(1, 1, 1, 32'h1, 1, 4'h1);
        rd(4, 1);
        step(1, 1, 1, 32'hF, 1, 4'hF);
        read_all_counts();

        tag = "R10";
        wr(0, 2, 1); wr(4, 32'hFFFF_FFFF, 1); wr(1, 32'h4, 1); rd(4, 1);
        wr(4, 32'hFFFF_FFFF, 1); step(1, 1, 1, 32'h4, 1, 4'h4); rd(4, 1);
        wr(4, 32'hFFFF_FFFF, 1); step(0, 0, 0, 0, 1, 4'h4); rd(4, 1);

        tag = "R11";
        wr(0, 3, 1);
        step(1, 1, 4, 32'h55, 1, 4'h8); rd(4, 1);

        tag = "R12";
        secure = 1'b1;
        wr(2, 1, 1);
        wr(1, 32'hF, 0); wr(2, 0, 0);
        read_all_counts();
        wr(2, 0, 1); rd(4, 0);
        secure = 1'b0;

        tag = "R2";
        for (int k = 0; k < 40; k++) begin
            step(1, 1, 1, k * 32'h1357, 1, 4'(k * 3));
            if (k % 5 == 0) step(1, 0, 4, 0, 1, 4'(k));
        end
        read_all_counts();

        finish_run();
    end
endmodule